// File: doc/BRIEF.md
# Byte-programmable nonvolatile page store with timed erase

This block models a small nonvolatile byte array together with the controller that guards it. The array holds 1024 bytes in 32 pages of 32 bytes. It answers to the 16-bit address window 0xF800 to 0xFBFF. A byte can be programmed only while it still holds the erased value 0xFF. The only way back to that value is to erase the whole page that holds the byte.

Erase is permitted only while an enable bit is set in a configuration register. The erase then runs for a fixed number of clock cycles and the busy output stays high for that time. The erase rewrites the page one byte per cycle during the first 32 cycles of the busy interval. This keeps the array a plain one-write-port memory. Reset clears the controller state but leaves the array contents alone, the way a nonvolatile store behaves. Requests that arrive while the block is busy are dropped and flagged.

Top module: `nvm_page_ctrl`

## Requirements
- R1: Only addresses 0xF800 to 0xFBFF (offset = address − 0xF800) reach the array. A program or erase request outside that window changes nothing, and a read outside it returns 0x00.
- R2: `rd_data` shows the byte at `rd_addr` one clock after the address is presented. At power-up every byte reads 0xFF.
- R3: A program request to a byte that currently reads 0xFF stores `prog_data`. The new value can be read back from the second clock after the request is taken.
- R4: A program request to a byte that does not read 0xFF leaves the byte unchanged and sets `err_prog`. `err_prog` stays set until reset.
- R5: An accepted erase sets all 32 bytes of the page selected by offset bits [9:5] to 0xFF. All other pages keep their contents.
- R6: A configuration write to address 0x90 stores bit 2 of the write data as the erase enable. A write to any other address does not change it. With the enable clear, an erase request has no effect: busy stays low, no flag is set and the contents are kept.
- R7: After an erase is accepted, `busy` is high for exactly ERASE_CYCLES consecutive cycles, starting at the next clock.
- R8: While `busy` is high, a program or enabled erase request is ignored and sets `err_busy`, which stays set until reset. If a program and an enabled erase arrive in the same cycle, the erase is taken and the program is dropped and flagged.
- R9: Reset clears `busy`, both error flags and the erase enable. It does not alter the array contents.
- R10: An accepted program request raises `busy` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| prog_req | input | 1 | Byte program request (one cycle) |
| prog_addr | input | 16 | Byte address for programming |
| prog_data | input | 8 | Byte value to program |
| erase_req | input | 1 | Page erase request (one cycle) |
| erase_addr | input | 16 | Any address inside the page to erase |
| rd_addr | input | 16 | Read address |
| rd_data | output | 8 | Byte read, one cycle after `rd_addr` |
| busy | output | 1 | High during the erase interval or the program check cycle |
| err_prog | output | 1 | Sticky: program to a byte that is not erased |
| err_busy | output | 1 | Sticky: request refused because the block was busy |

## Verification
The assertions check several rules on every cycle: both error flags stay set once set, an accepted erase raises busy on the next cycle, busy falls only when the cycle counter reaches its last value, a disabled erase never starts the erase sequencer, and the program path and the erase sweep never write the array in the same cycle. Only the bench scenarios can show the data outcomes. These are: bytes programmed into erased cells read back, refused writes leave the old value, an erase clears exactly one page, out-of-window requests leave no trace, and array contents survive reset while the enable bit does not.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t ERASED_BYTE = 8'hFF;
  localparam byte_t MISS_BYTE   = 8'h00;
endpackage

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  import nvm_pkg::*;

  byte_t cells [DEPTH];

  // Unprogrammed state at configuration time; reset never touches the cells.
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = ERASED_BYTE;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata_a <= cells[raddr_a];
    rdata_b <= cells[raddr_b];
  end
endmodule

// File: rtl/nvm_erase_seq.sv
module nvm_erase_seq #(
  parameter int PAGES        = 32,
  parameter int PAGE_BYTES   = 32,
  parameter int ERASE_CYCLES = 4_000_000,
  localparam int PW = $clog2(PAGES),
  localparam int BW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(ERASE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PW-1:0]    page_in,
  output logic             busy,
  output logic             sweep_we,
  output logic [PW+BW-1:0] sweep_addr
);
  logic [CW-1:0] cnt;
  logic [PW-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      page_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt    <= '0;
      page_q <= page_in;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(ERASE_CYCLES - 1)) busy <= 1'b0;
    end
  end

  // One byte of the page is restored per cycle at the head of the interval.
  assign sweep_we   = busy && (cnt < CW'(PAGE_BYTES));
  assign sweep_addr = {page_q, cnt[BW-1:0]};

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == CW'(ERASE_CYCLES - 1)));
endmodule

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl #(
  parameter int          ADDR_W       = 16,
  parameter int          CFG_AW       = 8,
  parameter logic [15:0] BASE_ADDR    = 16'hF800,
  parameter int          PAGES        = 32,
  parameter int          PAGE_BYTES   = 32,
  parameter int          ERASE_CYCLES = 4_000_000,
  parameter logic [7:0]  CFG_ADDR     = 8'h90,
  parameter int          CFG_BIT      = 2,
  localparam int DEPTH = PAGES * PAGE_BYTES,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(PAGES),
  localparam int BW    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] erase_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              err_prog,
  output logic              err_busy
);
  import nvm_pkg::*;

  logic [ADDR_W-1:0] off_p, off_e, off_r;
  logic hit_p, hit_e, hit_r;

  always_comb begin
    off_p = prog_addr  - ADDR_W'(BASE_ADDR);
    off_e = erase_addr - ADDR_W'(BASE_ADDR);
    off_r = rd_addr    - ADDR_W'(BASE_ADDR);
    hit_p = (prog_addr  >= ADDR_W'(BASE_ADDR)) && (off_p < ADDR_W'(DEPTH));
    hit_e = (erase_addr >= ADDR_W'(BASE_ADDR)) && (off_e < ADDR_W'(DEPTH));
    hit_r = (rd_addr    >= ADDR_W'(BASE_ADDR)) && (off_r < ADDR_W'(DEPTH));
  end

  // Configuration: erase enable bit
  logic erase_en_q;
  always_ff @(posedge clk) begin
    if (rst) erase_en_q <= 1'b0;
    else if (cfg_we && cfg_addr == CFG_AW'(CFG_ADDR)) erase_en_q <= cfg_wdata[CFG_BIT];
  end

  // Arbitration
  logic er_busy, prog_pend;
  logic prog_want, erase_want, erase_go, prog_go;
  always_comb begin
    busy       = er_busy | prog_pend;
    prog_want  = prog_req && hit_p;
    erase_want = erase_req && hit_e && erase_en_q;
    erase_go   = erase_want && !busy;
    prog_go    = prog_want && !busy && !erase_go;
  end

  // Program check stage: the cell is read in the accept cycle, judged next.
  logic [AW-1:0] pend_addr;
  byte_t         pend_data, chk_q, rd_q;
  logic          prog_we;
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_pend <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      prog_pend <= prog_go;
      if (prog_go) begin
        pend_addr <= off_p[AW-1:0];
        pend_data <= prog_data;
      end
    end
  end
  assign prog_we = prog_pend && (chk_q == ERASED_BYTE);

  // Sticky error flags
  always_ff @(posedge clk) begin
    if (rst) begin
      err_prog <= 1'b0;
      err_busy <= 1'b0;
    end else begin
      if (prog_pend && chk_q != ERASED_BYTE) err_prog <= 1'b1;
      if (((prog_want || erase_want) && busy) || (prog_want && erase_go)) err_busy <= 1'b1;
    end
  end

  // Erase sequencer
  logic          sweep_we;
  logic [AW-1:0] sweep_addr;
  nvm_erase_seq #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .start(erase_go),
    .page_in(off_e[AW-1:BW]),
    .busy(er_busy), .sweep_we(sweep_we), .sweep_addr(sweep_addr)
  );

  // Array write port shared by sweep and program
  logic          arr_we;
  logic [AW-1:0] arr_waddr;
  byte_t         arr_wdata;
  always_comb begin
    arr_we    = sweep_we | prog_we;
    arr_waddr = sweep_we ? sweep_addr : pend_addr;
    arr_wdata = sweep_we ? ERASED_BYTE : pend_data;
  end

  nvm_cell_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr_a(off_r[AW-1:0]), .rdata_a(rd_q),
    .raddr_b(off_p[AW-1:0]), .rdata_b(chk_q)
  );

  logic rd_hit_q;
  always_ff @(posedge clk) begin
    if (rst) rd_hit_q <= 1'b0;
    else     rd_hit_q <= hit_r;
  end
  assign rd_data = rd_hit_q ? rd_q : MISS_BYTE;

  assert_err_prog_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    err_prog |=> err_prog);
  assert_err_busy_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_busy |=> err_busy);
  assert_one_writer_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sweep_we, prog_we}));
  assert_disabled_erase_R6: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !erase_en_q && !er_busy) |=> !er_busy);
  assert_bad_prog_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (prog_pend && chk_q != ERASED_BYTE) |=> err_prog);
endmodule

// File: tb/sim_nvm_page_ctrl.sv
module sim_nvm_page_ctrl;
  localparam int EC = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic prog_req = 0; logic [15:0] prog_addr = 0; logic [7:0] prog_data = 0;
  logic erase_req = 0; logic [15:0] erase_addr = 0;
  logic [15:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic busy, err_prog, err_busy;

  always #2.5 clk = ~clk;

  nvm_page_ctrl #(.ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .erase_addr(erase_addr), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .err_prog(err_prog), .err_busy(err_busy));

  int runs = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       issued = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compares the read result in the cycle after each issued read.
  always @(posedge clk) begin
    if (issued) begin
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_addr = a; issued = 1; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    issued = 0;
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d, input bit chk_busy);
    @(negedge clk);
    prog_req = 1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_req = 0;
    if (chk_busy) check("R10 busy in check cycle", busy, 1);
    @(negedge clk);
    if (chk_busy) check("R10 busy drops after one cycle", busy, 0);
  endtask

  task automatic cfg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    check("R9 busy after reset", busy, 0);
    check("R9 err_prog after reset", err_prog, 0);
    check("R9 err_busy after reset", err_busy, 0);
    rd(16'hF800, 8'hFF, "R2 initial erased");
    rd(16'hFBFF, 8'hFF, "R2 initial erased top");

    prog(16'hF800, 8'h12, 1);
    prog(16'hF81F, 8'h34, 0);
    prog(16'hF820, 8'h56, 0);
    prog(16'hFBFF, 8'hA5, 0);
    rd(16'hF800, 8'h12, "R3 program p0 b0");
    rd(16'hF81F, 8'h34, "R3 program p0 b31");
    rd(16'hF820, 8'h56, "R3 program p1 b0");
    rd(16'hFBFF, 8'hA5, "R3 program last byte");
    check("R4 no error yet", err_prog, 0);

    prog(16'hF800, 8'h99, 0);
    check("R4 err_prog set", err_prog, 1);
    rd(16'hF800, 8'h12, "R4 content kept");
    repeat (3) @(negedge clk);
    check("R4 err_prog sticky", err_prog, 1);

    prog(16'hFC00, 8'h11, 0);
    prog(16'hF7FF, 8'h22, 0);
    rd(16'hFC00, 8'h00, "R1 read above window");
    rd(16'hF7FF, 8'h00, "R1 read below window");
    rd(16'hF800, 8'h12, "R1 no alias write");
    check("R1 no busy error from out-of-window", err_busy, 0);

    // Erase with enable clear
    @(negedge clk); erase_req = 1; erase_addr = 16'hF810;
    @(negedge clk); erase_req = 0;
    check("R6 disabled erase no busy", busy, 0);
    cfg(8'h91, 8'h04);
    @(negedge clk); erase_req = 1; erase_addr = 16'hF810;
    @(negedge clk); erase_req = 0;
    check("R6 other cfg address no enable", busy, 0);
    check("R6 no flag", err_busy, 0);
    rd(16'hF800, 8'h12, "R6 content kept");

    cfg(8'h90, 8'h04);
    @(negedge clk); erase_req = 1; erase_addr = 16'hF805;
    @(negedge clk); erase_req = 0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 3) begin prog_req = 1; prog_addr = 16'hF900; prog_data = 8'h5A; end
      else prog_req = 0;
      @(negedge clk);
    end
    prog_req = 0;
    check("R7 busy length", n, EC);
    check("R8 err_busy on request while busy", err_busy, 1);
    rd(16'hF800, 8'hFF, "R5 page byte 0 erased");
    rd(16'hF81F, 8'hFF, "R5 page byte 31 erased");
    rd(16'hF820, 8'h56, "R5 next page kept");
    rd(16'hFBFF, 8'hA5, "R5 last page kept");
    rd(16'hF900, 8'hFF, "R8 busy program ignored");
    prog(16'hF800, 8'h77, 0);
    rd(16'hF800, 8'h77, "R3 program after erase");

    do_reset();
    check("R9 err_busy cleared", err_busy, 0);
    check("R9 err_prog cleared", err_prog, 0);
    rd(16'hF800, 8'h77, "R9 content survives reset");
    @(negedge clk); erase_req = 1; erase_addr = 16'hF800;
    @(negedge clk); erase_req = 0;
    check("R9 enable cleared by reset", busy, 0);

    cfg(8'h90, 8'h04);
    @(negedge clk);
    erase_req = 1; erase_addr = 16'hFBE0;
    prog_req = 1; prog_addr = 16'hF840; prog_data = 8'h42;
    @(negedge clk);
    erase_req = 0; prog_req = 0;
    check("R8 simultaneous erase wins busy", busy, 1);
    check("R8 simultaneous program flagged", err_busy, 1);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R7 busy length second erase", n, EC);
    rd(16'hF840, 8'hFF, "R8 dropped program");
    rd(16'hFBFF, 8'hFF, "R5 last page erased");
    rd(16'hF800, 8'h77, "R5 other page kept");

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule